// File: doc/BRIEF.md
# Page Write Load Controller

This block sits behind an SRAM-style strobe interface and gathers host byte writes into a page buffer of 64 slots. The first accepted byte fixes the page (address bits 14 to 6) and opens a load window. Later bytes to the same page land in the slot chosen by address bits 5 to 0, in any order. A slot may be written again, and the newest value wins. The window stays open while bytes keep arriving. Once no byte has been accepted for a set number of clock cycles, the window closes and the block enters a timed programming cycle.

During programming the block reports busy and ignores every write strobe. After the programming time it scans the 64 slots in ascending order, one slot per clock. For each slot loaded in this window it drives one write into the behavioural memory array through the array-write port. Unloaded slots of the page are never touched. The inter-byte timeout and the programming time are parameters in clock cycles (`GAP_LIMIT_CYC`, `PROG_CYC`).

Strobe inputs are sampled on the clock. A write strobe is active while chip-enable and write-enable are both low. The address is taken in the first active cycle and the data in the last active cycle.

Top module: `pgload_ctrl`

## Requirements
- R1: After reset, busy and arr_we are low, and no programming starts without an accepted byte.
- R2: A byte is accepted only from a strobe during which ce_n and we_n are both low with oe_n high. With oe_n low, or with ce_n held high, no byte is loaded and no programming cycle starts.
- R3: The address is captured in the first clock cycle in which ce_n and we_n are both low. The data is captured in the last such cycle. Address changes after the start and data changes after the end have no effect.
- R4: An accepted byte restarts the gap timer. If no byte is accepted for GAP_LIMIT_CYC cycles, the load window closes and busy rises. Before that, busy stays low.
- R5: Bytes of one window may arrive in any slot order. A slot written twice is committed with its last value.
- R6: In the commit scan, arr_we pulses once for each loaded slot, in ascending slot order. arr_addr carries the page of the first byte in bits 14 to 6 and the slot in bits 5 to 0. Slots not loaded in the window are not written.
- R7: During a load window, a byte whose address bits 14 to 6 differ from those of the first byte is dropped and does not restart the gap timer.
- R8: Write strobes that begin while busy is high are ignored. They load nothing and start no further programming cycle.
- R9: busy stays high for exactly PROG_CYC + 64 cycles. It falls one clock after the last cycle of the commit scan.
- R10: arr_we is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 15 | Host byte address; bits 14..6 page, 5..0 slot |
| wdata | input | 8 | Host write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| busy | output | 1 | High during programming and commit scan |
| arr_we | output | 1 | Array write strobe, one cycle per committed byte |
| arr_addr | output | 15 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions assume that ce_n, we_n, oe_n, addr and wdata are synchronous to clk, and that reset is held at the start of the run. They also assume that each write strobe stays active for at least one sampled cycle, so that its start and its end fall on different clock edges. The bench changes every input on the falling clock edge and holds each strobe low for two or more cycles. It spaces same-page bytes well inside the gap limit and leaves idle stretches well beyond it, so no check depends on which of a byte and a timeout wins on a shared edge.

// File: rtl/pgload_pkg.sv
package pgload_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int SLOT_W = 6;
    localparam int PAGE_W = ADDR_W - SLOT_W;
    localparam int SLOTS  = 1 << SLOT_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [SLOTS-1:0]  mask_t;

    // One completed host strobe
    typedef struct packed {
        logic  valid;
        addr_t addr;
        data_t data;
    } byte_evt_t;

    // One write toward the memory array
    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t data;
    } arr_wr_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_PROG,
        PH_COMMIT
    } phase_e;

    function automatic page_t page_of(addr_t a);
        return a[ADDR_W-1:SLOT_W];
    endfunction

    function automatic slot_t slot_of(addr_t a);
        return a[SLOT_W-1:0];
    endfunction
endpackage

// File: rtl/pgload_strobe.sv
// Turns sampled host strobes into single-cycle byte events.
module pgload_strobe
    import pgload_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      block,
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    input  addr_t     addr,
    input  data_t     wdata,
    output byte_evt_t evt
);
    logic  act_now;
    logic  act_q;
    logic  armed_q;
    addr_t addr_q;
    data_t data_q;

    assign act_now = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            armed_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            act_q <= act_now;
            if (act_now && !act_q) begin
                // later of the two falling edges: take the address
                armed_q <= oe_n && !block;
                addr_q  <= addr;
            end else if (act_now && !oe_n) begin
                armed_q <= 1'b0;
            end
            if (act_now) begin
                // keeps the value of the last active cycle
                data_q <= wdata;
            end
        end
    end

    always_comb begin
        evt.valid = act_q && !act_now && armed_q;
        evt.addr  = addr_q;
        evt.data  = data_q;
    end
endmodule

// File: rtl/pgload_pagebuf.sv
// Page buffer: one data register and one loaded flag per slot.
module pgload_pagebuf
    import pgload_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  data_t wr_data,
    input  logic  clr,
    input  slot_t rd_slot,
    output data_t rd_data,
    output logic  rd_loaded,
    output mask_t mask
);
    data_t slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mask[g] <= 1'b0;
            end else if (clr) begin
                mask[g] <= 1'b0;
            end else if (wr_en && wr_slot == slot_t'(g)) begin
                mask[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == slot_t'(g)) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data   = slot_q[rd_slot];
    assign rd_loaded = mask[rd_slot];
endmodule

// File: rtl/pgload_seq.sv
// Phase sequencer: load window, programming timer, commit scan.
module pgload_seq
    import pgload_pkg::*;
#(
    parameter int GAP_LIMIT_CYC = 7500,
    parameter int PROG_CYC      = 150000
) (
    input  logic      clk,
    input  logic      rst,
    input  byte_evt_t evt,
    input  logic      rd_loaded,
    input  data_t     rd_data,
    output logic      buf_wr_en,
    output slot_t     buf_wr_slot,
    output data_t     buf_wr_data,
    output logic      buf_clr,
    output slot_t     scan_idx,
    output logic      busy,
    output logic      loading,
    output logic      scan_last,
    output arr_wr_t   arr
);
    localparam int GAP_W = $clog2(GAP_LIMIT_CYC + 1);
    localparam int PRG_W = $clog2(PROG_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'(GAP_LIMIT_CYC - 1);
    localparam logic [PRG_W-1:0] PRG_END = PRG_W'(PROG_CYC - 1);

    phase_e           phase_q;
    page_t            page_q;
    logic [GAP_W-1:0] gap_q;
    logic [PRG_W-1:0] prg_q;
    slot_t            idx_q;
    logic             accept;

    always_comb begin
        accept = 1'b0;
        if (evt.valid) begin
            if (phase_q == PH_IDLE) begin
                accept = 1'b1;
            end else if (phase_q == PH_LOAD && page_of(evt.addr) == page_q) begin
                accept = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            page_q  <= '0;
            gap_q   <= '0;
            prg_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        page_q  <= page_of(evt.addr);
                        gap_q   <= '0;
                        phase_q <= PH_LOAD;
                    end
                end
                PH_LOAD: begin
                    if (accept) begin
                        gap_q <= '0;
                    end else if (gap_q == GAP_END) begin
                        prg_q   <= '0;
                        phase_q <= PH_PROG;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (prg_q == PRG_END) begin
                        idx_q   <= '0;
                        phase_q <= PH_COMMIT;
                    end else begin
                        prg_q <= prg_q + 1'b1;
                    end
                end
                PH_COMMIT: begin
                    if (idx_q == slot_t'(SLOTS - 1)) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign buf_wr_en   = accept;
    assign buf_wr_slot = slot_of(evt.addr);
    assign buf_wr_data = evt.data;
    assign scan_idx    = idx_q;
    assign busy        = (phase_q == PH_PROG) || (phase_q == PH_COMMIT);
    assign loading     = (phase_q == PH_LOAD);
    assign scan_last   = (phase_q == PH_COMMIT) && (idx_q == slot_t'(SLOTS - 1));
    assign buf_clr     = scan_last;

    always_comb begin
        arr.we   = (phase_q == PH_COMMIT) && rd_loaded;
        arr.addr = {page_q, idx_q};
        arr.data = rd_data;
    end
endmodule

// File: rtl/pgload_ctrl.sv
module pgload_ctrl
    import pgload_pkg::*;
#(
    parameter int GAP_LIMIT_CYC = 7500,
    parameter int PROG_CYC      = 150000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [14:0] addr,
    input  logic [7:0]  wdata,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    output logic        busy,
    output logic        arr_we,
    output logic [14:0] arr_addr,
    output logic [7:0]  arr_wdata
);
    byte_evt_t evt;
    logic      buf_wr_en;
    slot_t     buf_wr_slot;
    data_t     buf_wr_data;
    logic      buf_clr;
    slot_t     scan_idx;
    data_t     rd_data;
    logic      rd_loaded;
    mask_t     mask;
    logic      loading;
    logic      scan_last;
    arr_wr_t   arr;

    pgload_strobe u_strobe (
        .clk   (clk),
        .rst   (rst),
        .block (busy),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .addr  (addr),
        .wdata (wdata),
        .evt   (evt)
    );

    pgload_pagebuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (buf_wr_en),
        .wr_slot   (buf_wr_slot),
        .wr_data   (buf_wr_data),
        .clr       (buf_clr),
        .rd_slot   (scan_idx),
        .rd_data   (rd_data),
        .rd_loaded (rd_loaded),
        .mask      (mask)
    );

    pgload_seq #(
        .GAP_LIMIT_CYC (GAP_LIMIT_CYC),
        .PROG_CYC      (PROG_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rd_loaded   (rd_loaded),
        .rd_data     (rd_data),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_slot (buf_wr_slot),
        .buf_wr_data (buf_wr_data),
        .buf_clr     (buf_clr),
        .scan_idx    (scan_idx),
        .busy        (busy),
        .loading     (loading),
        .scan_last   (scan_last),
        .arr         (arr)
    );

    assign arr_we    = arr.we;
    assign arr_addr  = arr.addr;
    assign arr_wdata = arr.data;
endmodule

// File: rtl/pgload_chk.sv
module pgload_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        arr_we,
    input logic [14:0] arr_addr,
    input logic        loading,
    input logic        scan_last,
    input logic [63:0] mask
);
    assert_we_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_busy_from_load_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(loading));

    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(scan_last));

    assert_page_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[14:6] == $past(arr_addr[14:6])));

    assert_slot_rising_R6: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> (arr_addr[5:0] > $past(arr_addr[5:0])));

    assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !scan_last) |=> $stable(mask));
endmodule

bind pgload_ctrl pgload_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_addr  (arr_addr),
    .loading   (loading),
    .scan_last (scan_last),
    .mask      (mask)
);

// File: tb/sim_pgload_ctrl.sv
module sim_pgload_ctrl;
    localparam int GAP = 20;
    localparam int PC  = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        busy;
    logic        arr_we;
    logic [14:0] arr_addr;
    logic [7:0]  arr_wdata;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int commits = 0;
    int busy_cnt = 0;
    int last_we_cyc = 0;
    int fall_cyc = 0;
    logic busy_prev = 1'b0;
    logic [7:0] mem [int];

    pgload_ctrl #(.GAP_LIMIT_CYC(GAP), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #2 clk = ~clk;

    // array model and counters, sampled mid-cycle
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (arr_we) begin
                mem[int'(arr_addr)] = arr_wdata;
                commits <= commits + 1;
                last_we_cyc <= cyc;
            end
            if (busy) busy_cnt <= busy_cnt + 1;
            if (busy_prev && !busy) fall_cyc <= cyc;
            busy_prev <= busy;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [14:0] a, input logic [7:0] d);
        addr = a; wdata = d; oe_n = 1'b1; ce_n = 1'b0;
        tick(1); we_n = 1'b0;
        tick(2); we_n = 1'b1;
        tick(1); ce_n = 1'b1;
    endtask

    task automatic wait_busy();
        int n = 0;
        while (!busy && n < 3000) begin tick(1); n++; end
        if (n >= 3000) check("hang waiting for busy", 0, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!busy && n < 3000) begin tick(1); n++; end
        while (busy && n < 3000) begin tick(1); n++; end
        tick(1);
        if (n >= 3000) check("hang waiting for idle", 0, 1);
    endtask

    function automatic int rd(input int a);
        return mem.exists(a) ? int'(mem[a]) : -1;
    endfunction

    task automatic t_reset();
        check("R1 busy after reset", int'(busy), 0);
        check("R1 arr_we after reset", int'(arr_we), 0);
        tick(GAP + 10);
        check("R1 no programming without bytes", int'(busy), 0);
    endtask

    task automatic t_single();
        int c0 = commits;
        int b0 = busy_cnt;
        wr_byte(15'h00C5, 8'h3C);
        tick(GAP - 6);
        check("R4 window open before limit", int'(busy), 0);
        tick(12);
        check("R4 busy after gap limit", int'(busy), 1);
        wait_done();
        check("R6 single commit count", commits - c0, 1);
        check("R6 single byte value", rd(32'h00C5), 8'h3C);
        check("R9 busy length", busy_cnt - b0, PC + 64);
    endtask

    task automatic t_any_order();
        int c0 = commits;
        int base = 32'h2A80;
        wr_byte(15'h2A80 + 15'd10, 8'h11);
        wr_byte(15'h2A80 + 15'd2,  8'h22);
        wr_byte(15'h2A80 + 15'd63, 8'h33);
        wr_byte(15'h2A80,          8'h44);
        wr_byte(15'h2A80 + 15'd10, 8'h55);
        wait_done();
        check("R6 commits for four slots", commits - c0, 4);
        check("R5 rewritten slot keeps last", rd(base + 10), 8'h55);
        check("R5 slot 2", rd(base + 2), 8'h22);
        check("R5 slot 63", rd(base + 63), 8'h33);
        check("R5 slot 0", rd(base), 8'h44);
        check("R6 unloaded slot untouched", int'(mem.exists(base + 1)), 0);
    endtask

    task automatic t_ce_ctrl();
        int c0 = commits;
        addr = 15'h1100; wdata = 8'h01; oe_n = 1'b1; we_n = 1'b0;
        tick(1); ce_n = 1'b0;
        tick(1); addr = 15'h1107;
        tick(1); wdata = 8'hA7;
        tick(1); ce_n = 1'b1; wdata = 8'hEE;
        tick(1); we_n = 1'b1;
        wait_done();
        check("R3 one byte from CE strobe", commits - c0, 1);
        check("R3 address from first active cycle, data from last", rd(32'h1100), 8'hA7);
        check("R3 later address unused", int'(mem.exists(32'h1107)), 0);
    endtask

    task automatic t_inhibit();
        int c0 = commits;
        addr = 15'h0400; wdata = 8'h99; oe_n = 1'b0; ce_n = 1'b0;
        tick(1); we_n = 1'b0;
        tick(2); we_n = 1'b1;
        tick(1); ce_n = 1'b1; oe_n = 1'b1;
        tick(1); we_n = 1'b0;
        tick(2); we_n = 1'b1;
        tick(GAP + 10);
        check("R2 inhibited strobes start nothing", int'(busy), 0);
        check("R2 inhibited strobes commit nothing", commits - c0, 0);
    endtask

    task automatic t_foreign();
        int c0 = commits;
        wr_byte(15'h0A41, 8'h5D);
        wr_byte(15'h0E41, 8'h66);
        tick(3);
        wr_byte(15'h0E42, 8'h67);
        tick(15);
        check("R7 foreign byte keeps timer running", int'(busy), 1);
        wait_done();
        check("R7 only own page committed", commits - c0, 1);
        check("R7 own byte value", rd(32'h0A41), 8'h5D);
        check("R7 foreign byte dropped", int'(mem.exists(32'h0E42)), 0);
    endtask

    task automatic t_busy_ignored();
        int c0 = commits;
        wr_byte(15'h3007, 8'h71);
        wait_busy();
        tick(3);
        wr_byte(15'h3008, 8'h72);
        wr_byte(15'h5008, 8'h73);
        wait_done();
        tick(GAP + 10);
        check("R8 no further cycle after busy strobes", int'(busy), 0);
        check("R8 commit count", commits - c0, 1);
        check("R8 strobe during busy not loaded", int'(mem.exists(32'h3008)), 0);
    endtask

    task automatic t_full_page();
        int c0 = commits;
        int b0 = busy_cnt;
        int bad = 0;
        for (int s = 63; s >= 0; s--) begin
            wr_byte(15'h7FC0 + 15'(s), 8'(s) ^ 8'h5A);
        end
        wait_done();
        check("R6 full page commit count", commits - c0, 64);
        for (int s = 0; s < 64; s++) begin
            if (rd(32'h7FC0 + s) != (s ^ 32'h5A)) bad++;
        end
        check("R6 full page contents", bad, 0);
        check("R9 busy falls one clock after last commit", fall_cyc, last_we_cyc + 1);
        check("R9 full page busy length", busy_cnt - b0, PC + 64);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_single();
        t_any_order();
        t_ce_ctrl();
        t_inhibit();
        t_foreign();
        t_busy_ignored();
        t_full_page();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule